// File: doc/BRIEF.md
# Serial Receiver with Per-Word Line Status

This block turns an asynchronous serial line into received words. It uses the same framing control byte as the companion transmitter: word length, parity enable, even or odd parity, and stick parity. A free-running oversampling tick (16 ticks per bit by default) paces the receiver. The line goes through a two-stage synchronizer. Each falling edge is then confirmed at mid-start-bit, and the data, parity and stop bits are each sampled at the middle of their bit time.

Each completed word goes into a 16-entry receive FIFO together with its own parity, framing and break flags. The status byte shows the flags of the word at the FIFO head. It also shows a summary bit that stays set while any held word carries an error, a sticky overrun flag, and two transmitter-state bits that pass through from inputs. The host reads the head through `data_o` and `status_o`, removes it with `pop_i`, and pulses `stat_rd_i` to mark that the status byte was read.

Top module: `uart_rx_lsr`

## Requirements
- R1: Control byte `ctrl_i`: bits [1:0] = n select a word of 5+n data bits, received least significant bit first. Bit 3 enables a parity bit after the data. Bit 4 selects even parity and bit 5 selects stick parity. Bits 2, 6 and 7 are ignored. Unused upper bits of `data_o` read 0.
- R2: A falling edge starts a frame only if the line is still 0 on the 8th tick after the edge. Otherwise nothing is loaded and the status does not change.
- R3: `status_o[0]` (data ready) becomes 1 only after a complete word has been written into the FIFO. It returns to 0 once `pop_i` has emptied the FIFO.
- R4: `status_o[2]` is set for a word whose parity bit differs from the expected value. Even mode expects the XOR of the data bits. Odd mode expects its inverse. Stick mode expects 0 when bit 4 is 1 and expects 1 when bit 4 is 0.
- R5: `status_o[3]` is set for a word whose first stop bit samples as 0. After such a word, the receiver waits for the line to return to 1 before it looks for a new start bit.
- R6: A frame whose data, parity and stop samples are all 0 is a break. It loads exactly one word of value 0 with `status_o[4]` and `status_o[3]` set and `status_o[2]` clear, however long the line stays low.
- R7: The FIFO holds 16 words and returns them in arrival order. `pop_i` removes the head word when the FIFO is not empty.
- R8: A word that completes while the FIFO is full, with no pop in the same cycle, is discarded and sets `status_o[1]`. The held words stay unchanged. A `stat_rd_i` pulse clears `status_o[1]`, except when a new word is discarded in that same cycle.
- R9: `status_o[4:2]` show the flags of the head word. They read 0 when the FIFO is empty.
- R10: `status_o[7]` is 1 exactly while at least one held word has a parity, framing or break flag.
- R11: `status_o[5]` follows `thr_empty_i` and `status_o[6]` follows `tx_idle_i`.
- R12: After reset, `data_o` and `status_o` bits 0–4 and 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, one cycle wide |
| ctrl_i | input | 8 | Framing control byte |
| pop_i | input | 1 | Remove the head word |
| stat_rd_i | input | 1 | Status byte read, clears overrun |
| thr_empty_i | input | 1 | Transmitter holding stage empty |
| tx_idle_i | input | 1 | Transmitter fully idle |
| data_o | output | 8 | Head word data |
| status_o | output | 8 | Line status byte |

## Verification
If the bit counter or the sampling point drifts, the error shows up within one frame: `data_o` carries shifted bits or a false parity or framing flag. A flag counter that is out of step with the FIFO contents shows up as a `status_o[7]` that does not clear when the last flagged word is popped. A wrong full/empty count shows up as an overrun raised too early or too late during a 17-word burst, or as a word delivered out of order during the drain that follows. The bench therefore compares the whole status byte and head data after every frame, pop and status read, against a queue model built from the requirements.

// File: rtl/uart_rx_lsr_pkg.sv
`timescale 1ns/1ps
package uart_rx_lsr_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              bi;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  typedef struct packed {
    logic       par_stick;
    logic       par_even;
    logic       par_en;
    logic [1:0] wlen;
  } line_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  function automatic line_cfg_t decode_ctrl(input logic [7:0] c);
    line_cfg_t r;
    r.wlen      = c[1:0];
    r.par_en    = c[3];
    r.par_even  = c[4];
    r.par_stick = c[5];
    return r;
  endfunction
endpackage

// File: rtl/uart_rx_lsr_sync.sv
`timescale 1ns/1ps
module uart_rx_lsr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_lsr_frame.sv
`timescale 1ns/1ps
module uart_rx_lsr_frame
  import uart_rx_lsr_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rx_i,
  input  logic      tick_i,
  input  line_cfg_t cfg_i,
  output logic      vld_o,
  output rx_word_t  word_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              low_q;
  line_cfg_t         cfg_q;

  logic             bit_end;
  logic [IDX_W-1:0] last_idx;
  logic             exp_par;
  logic             stop_bi;

  assign bit_end  = tick_i && (cnt_q == LAST_CNT);
  assign last_idx = IDX_W'(4) + IDX_W'(cfg_q.wlen);
  assign exp_par  = cfg_q.par_stick ? ~cfg_q.par_even
                  : (cfg_q.par_even ? ^sh_q : ~^sh_q);
  assign stop_bi  = ~rx_i & low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      low_q   <= 1'b0;
      cfg_q   <= '0;
      vld_o   <= 1'b0;
      word_o  <= '0;
    end else begin
      vld_o <= 1'b0;
      if (state_q inside {ST_DATA, ST_PAR, ST_STOP} && tick_i)
        cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (!rx_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
        end
        ST_START: if (tick_i) begin
          if (cnt_q == MID_CNT) begin
            cnt_q <= '0;
            if (rx_i) state_q <= ST_IDLE;
            else begin
              state_q <= ST_DATA;
              idx_q   <= '0;
              sh_q    <= '0;
              low_q   <= 1'b1;
              cfg_q   <= cfg_i;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: if (bit_end) begin
          sh_q[idx_q] <= rx_i;
          low_q       <= low_q & ~rx_i;
          if (idx_q == last_idx) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_PAR: if (bit_end) begin
          par_q   <= rx_i;
          low_q   <= low_q & ~rx_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (bit_end) begin
          vld_o       <= 1'b1;
          word_o.data <= sh_q;
          word_o.fe   <= ~rx_i;
          word_o.bi   <= stop_bi;
          word_o.pe   <= ~stop_bi & cfg_q.par_en & (par_q != exp_par);
          state_q     <= rx_i ? ST_IDLE : ST_HOLD;
        end
        ST_HOLD: if (rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_lsr_fifo.sv
`timescale 1ns/1ps
module uart_rx_lsr_fifo
  import uart_rx_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  rx_word_t word_i,
  input  logic     pop_i,
  input  logic     clr_ovr_i,
  output rx_word_t head_o,
  output logic     empty_o,
  output logic     full_o,
  output logic     ovr_o,
  output logic     err_any_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q, err_q;
  logic             do_pop, do_push, drop;
  logic             in_err, head_err;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign do_pop   = pop_i & ~empty_o;
  assign do_push  = push_i & (~full_o | do_pop);
  assign drop     = push_i & full_o & ~do_pop;
  assign head_o   = empty_o ? '0 : mem_q[rd_q];
  assign in_err   = word_i.pe | word_i.fe | word_i.bi;
  assign head_err = head_o.pe | head_o.fe | head_o.bi;
  assign err_any_o = (err_q != '0);

  always_ff @(posedge clk_i)
    if (do_push) mem_q[wr_q] <= word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
      ovr_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      unique case ({do_push & in_err, do_pop & head_err})
        2'b10:   err_q <= err_q + 1'b1;
        2'b01:   err_q <= err_q - 1'b1;
        default: err_q <= err_q;
      endcase
      if (drop)           ovr_o <= 1'b1;
      else if (clr_ovr_i) ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_lsr.sv
`timescale 1ns/1ps
module uart_rx_lsr
  import uart_rx_lsr_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [7:0] ctrl_i,
  input  logic       pop_i,
  input  logic       stat_rd_i,
  input  logic       thr_empty_i,
  input  logic       tx_idle_i,
  output logic [7:0] data_o,
  output logic [7:0] status_o
);
  logic      rx_s;
  logic      frm_vld;
  rx_word_t  frm_word;
  rx_word_t  head;
  logic      fifo_empty, fifo_full, ovr, err_any;
  logic      unused_ctrl;

  assign unused_ctrl = ^{ctrl_i[7:6], ctrl_i[2]};

  uart_rx_lsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_lsr_frame #(.OSR(OSR)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_s),
    .tick_i(tick_i),
    .cfg_i (decode_ctrl(ctrl_i)),
    .vld_o (frm_vld),
    .word_o(frm_word)
  );

  uart_rx_lsr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (frm_vld),
    .word_i   (frm_word),
    .pop_i    (pop_i),
    .clr_ovr_i(stat_rd_i),
    .head_o   (head),
    .empty_o  (fifo_empty),
    .full_o   (fifo_full),
    .ovr_o    (ovr),
    .err_any_o(err_any)
  );

  assign data_o   = head.data;
  assign status_o = {err_any, tx_idle_i, thr_empty_i,
                     head.bi, head.fe, head.pe, ovr, ~fifo_empty};
endmodule

// File: rtl/uart_rx_lsr_chk.sv
`timescale 1ns/1ps
module uart_rx_lsr_chk
  import uart_rx_lsr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pop_i,
  input logic       stat_rd_i,
  input logic [7:0] data_o,
  input logic [7:0] status_o,
  input logic       frm_vld,
  input rx_word_t   frm_word,
  input logic       fifo_full
);
  logic dropping;
  assign dropping = frm_vld && fifo_full && !pop_i;

  AST_BREAK_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld && frm_word.bi |-> frm_word.fe && !frm_word.pe && frm_word.data == '0); // R6
  AST_DR_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(frm_vld)); // R3
  AST_OVR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dropping |=> status_o[1]); // R8
  AST_OVR_HEAD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dropping |=> $stable(data_o) && $stable(status_o[4:2])); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !dropping |=> !status_o[1]); // R8
  AST_EMPTY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[0] |-> status_o[4:2] == 3'b000 && !status_o[7] && data_o == 8'h00); // R9
  AST_SUMMARY_COVERS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o[4:2]) |-> status_o[7]); // R10
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pop_i    (pop_i),
  .stat_rd_i(stat_rd_i),
  .data_o   (data_o),
  .status_o (status_o),
  .frm_vld  (frm_vld),
  .frm_word (frm_word),
  .fifo_full(fifo_full)
);

// File: tb/uart_rx_lsr_bench.sv
`timescale 1ns/1ps
module uart_rx_lsr_bench;
  logic       clk = 1'b0, rst_ni = 1'b0, rx_i = 1'b1, tick_i = 1'b0;
  logic       pop_i = 1'b0, stat_rd_i = 1'b0, thr_empty_i = 1'b1, tx_idle_i = 1'b1;
  logic [7:0] ctrl_i = 8'h03;
  logic [7:0] data_o, status_o;

  int checks = 0, fails = 0;
  logic [10:0] mq[$];   // {bi, fe, pe, data}
  bit m_ovr = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick_i <= ~tick_i;  // one tick every 2 clocks

  uart_rx_lsr u_uart_rx_lsr (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx_i), .tick_i(tick_i), .ctrl_i(ctrl_i),
    .pop_i(pop_i), .stat_rd_i(stat_rd_i), .thr_empty_i(thr_empty_i),
    .tx_idle_i(tx_idle_i), .data_o(data_o), .status_o(status_o)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic any = 1'b0;
    logic [10:0] h = (mq.size() != 0) ? mq[0] : 11'h0;
    foreach (mq[i]) if (|mq[i][10:8]) any = 1'b1;
    return {any, tx_idle_i, thr_empty_i, h[10], h[9], h[8], m_ovr, mq.size() != 0};
  endfunction

  task automatic check_all(string tag);
    chk(tag, "status", status_o, exp_status());
    chk(tag, "data", data_o, (mq.size() != 0) ? mq[0][7:0] : 8'h00);
  endtask

  function automatic logic par_of(logic [7:0] d, logic [7:0] c);
    if (c[5]) return ~c[4];
    return c[4] ? ^d : ~^d;
  endfunction

  task automatic bit_out(logic b);
    rx_i = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic [7:0] c, bit pflip, bit stop_v);
    int nb = 5 + int'(c[1:0]);
    logic [7:0] dm = d & 8'((9'h1 << nb) - 1);
    logic p = par_of(dm, c) ^ pflip;
    logic fe, bi, pe;
    ctrl_i = c;
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(dm[i]);
    if (c[3]) bit_out(p);
    bit_out(stop_v);
    bit_out(1'b1);
    fe = !stop_v;
    bi = fe && dm == 8'h00 && (!c[3] || !p);
    pe = c[3] && pflip && !bi;
    if (mq.size() < 16) mq.push_back({bi, fe, pe, dm});
    else m_ovr = 1'b1;
  endtask

  task automatic pop_one();
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
    if (mq.size() != 0) void'(mq.pop_front());
    @(negedge clk);
  endtask

  task automatic stat_read();
    stat_rd_i = 1'b1;
    @(negedge clk);
    stat_rd_i = 1'b0;
    m_ovr = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    while (mq.size() != 0) begin
      check_all(tag);
      pop_one();
    end
    check_all(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R12");

    // R11 pass-through
    thr_empty_i = 1'b0; tx_idle_i = 1'b0; @(negedge clk);
    check_all("R11");
    thr_empty_i = 1'b1; tx_idle_i = 1'b0; @(negedge clk);
    check_all("R11");
    tx_idle_i = 1'b1;

    // R1 / R3 plain 8-bit word
    send_frame(8'hA5, 8'h03, 1'b0, 1'b1);
    check_all("R3");
    chk("R1", "data 8 bit", data_o, 8'hA5);
    pop_one();
    check_all("R3");

    // R1 5-bit word masks upper bits
    send_frame(8'hFF, 8'h00, 1'b0, 1'b1);
    chk("R1", "data 5 bit", data_o, 8'h1F);
    pop_one();

    // R4 parity modes
    send_frame(8'h37, 8'h1B, 1'b0, 1'b1);  // even, good
    send_frame(8'h37, 8'h0B, 1'b1, 1'b1);  // odd, bad
    send_frame(8'h12, 8'h3B, 1'b0, 1'b1);  // stick, expects 0
    send_frame(8'h12, 8'h2B, 1'b1, 1'b1);  // stick, expects 1, sent 0
    drain("R4");

    // R5 framing error, then R9 head flags
    send_frame(8'h55, 8'h03, 1'b0, 1'b0);
    send_frame(8'h66, 8'h03, 1'b0, 1'b1);
    check_all("R5");
    pop_one();
    check_all("R9");
    pop_one();

    // R6 short break and long break
    send_frame(8'h00, 8'h03, 1'b0, 1'b0);
    check_all("R6");
    pop_one();
    ctrl_i = 8'h1B;
    rx_i = 1'b0;
    repeat (32 * 30) @(negedge clk);
    rx_i = 1'b1;
    repeat (64) @(negedge clk);
    mq.push_back({1'b1, 1'b1, 1'b0, 8'h00});
    check_all("R6");
    chk("R6", "single break word", {7'h0, status_o[0]}, 8'h01);
    pop_one();
    check_all("R6");

    // R2 glitch shorter than half a bit
    rx_i = 1'b0;
    repeat (8) @(negedge clk);
    rx_i = 1'b1;
    repeat (96) @(negedge clk);
    check_all("R2");
    send_frame(8'h3C, 8'h03, 1'b0, 1'b1);
    check_all("R2");
    pop_one();

    // random traffic
    for (int n = 0; n < 50; n++) begin
      logic [7:0] c = 8'($urandom) & 8'h3B;
      int e = int'($urandom % 8);
      send_frame(8'($urandom), c, e == 0, e != 1);
      check_all("R9");
      if ($urandom % 3 == 0) begin pop_one(); check_all("R7"); end
      if ($urandom % 5 == 0) begin stat_read(); check_all("R8"); end
    end
    drain("R10");
    stat_read();

    // R8 overrun with 17 words, one flagged (R10)
    for (int i = 0; i < 17; i++)
      send_frame(8'(i * 13 + 1), 8'h03, 1'b0, i != 2);
    check_all("R8");
    chk("R8", "overrun bit", {7'h0, status_o[1]}, 8'h01);
    stat_read();
    check_all("R8");
    chk("R7", "oldest first", data_o, 8'h01);
    drain("R7");
    chk("R10", "summary clear", {7'h0, status_o[7]}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule